// File: doc/BRIEF.md
# Segment Access Rights Check Unit

This unit carries out the access-rights load of a protected-mode segmented processor. A one-cycle start pulse supplies a 16-bit segment selector, the current privilege level, the operand size, the base and limit of both descriptor tables and the processor mode. The unit then makes sure the selector is usable and lies inside its table. It fetches the upper doubleword of the descriptor through a simple read port and checks the descriptor's type and privilege. It finishes with a one-cycle completion pulse.

On success it raises the zero flag and a write-enable, and it presents the descriptor doubleword masked according to the operand size. On any failed check it clears the zero flag and leaves the destination word unchanged. Outside protected mode no check is made and an undefined-opcode fault is signalled instead. The instruction decoder and register file sit around this unit: they drive the start pulse and consume the completion outputs.

Top module: `sar_check_unit`

## Requirements
- R1: After reset `done_o`, `busy_o`, `rd_req_o`, `zf_o`, `we_o`, `ud_fault_o` are 0 and `result_o` is 0.
- R2: Mode encoding is 2'b01 = protected, 2'b00 = real-address, 2'b10 = virtual-8086 (2'b11 is also treated as not protected). A start in any mode other than 2'b01 completes with `ud_fault_o`=1, `zf_o`=0, `we_o`=0 and issues no read.
- R3: The selector layout is index in bits 15:3, table select in bit 2 (1 = local, 0 = global) and requested privilege level in bits 1:0. A selector whose bits 15:2 are all zero is null: the operation fails with no read. A local-table selector with index 0 is not null.
- R4: The operation fails with no read when index*8+7 exceeds the limit of the selected table. When it equals the limit, the check passes.
- R5: Exactly one read is issued per checked selector: `rd_req_o` is high for a single cycle, with `rd_addr_o` = table base + index*8 + 4.
- R6: In the descriptor doubleword, bits 11:8 are the type, bit 12 is S (1 = code/data), bits 14:13 are the DPL and bit 15 is P. Every descriptor with S=1 passes the type check.
- R7: With S=0, only types 1, 2, 3, 4, 5, 9, B and C pass the type check. Types 0, 6, 7, 8, A, D, E and F fail.
- R8: Unless the descriptor is conforming code, the operation fails when the current privilege level > DPL or when the requested privilege level > DPL. Both values are compared as unsigned numbers.
- R9: A conforming code descriptor (S=1, type bit 3 = 1, type bit 2 = 1) skips the privilege check.
- R10: With `op32_i`=1 the result is the doubleword ANDed with 0x00FFFF00.
- R11: With `op32_i`=0 the result is the low 16 bits ANDed with 0xFF00, and bits 31:16 are zero.
- R12: `done_o` is a one-cycle pulse. On success `zf_o`=1 and `we_o`=1 and `result_o` takes the new value. On failure `zf_o`=0 and `we_o`=0 and `result_o` keeps its previous value.
- R13: `done_o` is high in the cycle after the start edge when the mode is not protected. After a selector failure it is high in the cycle after the second edge. On the read path it is high in the cycle after the second edge following the edge where `rd_valid_i` is sampled high.
- R14: A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| sel_i | input | 16 | Segment selector |
| cpl_i | input | 2 | Current privilege level |
| op32_i | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| mode_i | input | 2 | Processor mode |
| gdt_base_i | input | ADDR_W | Global table base address |
| gdt_limit_i | input | LIM_W | Global table limit |
| ldt_base_i | input | ADDR_W | Local table base address |
| ldt_limit_i | input | LIM_W | Local table limit |
| rd_req_o | output | 1 | Descriptor read request, one cycle |
| rd_addr_o | output | ADDR_W | Read address of the upper doubleword |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| zf_o | output | 1 | Zero-flag value, valid with done |
| we_o | output | 1 | Destination write-enable, valid with done |
| ud_fault_o | output | 1 | Undefined-opcode fault, valid with done |
| result_o | output | 32 | Masked access rights; unchanged on failure |

## Verification
Completion is due one cycle after the start edge on a mode fault and two cycles after it on a selector failure. On the read path it is due two edges after the read data is accepted, so with a memory model answering W cycles late, done falls four plus W sampling points after the start. The bench drives and samples on the falling edge and counts falling edges from start until done. It compares that count to the latency expected for the path before it reads the flags, the result, the request count and the read address. One cycle later it confirms that done has dropped.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK_SEL,
      ST_READ,
      ST_CHECK_DESC,
      ST_DONE
   } sar_state_e;

   typedef struct packed {
      logic [12:0] index;
      logic        local_tbl;
      logic [1:0]  rpl;
   } sar_sel_t;

   localparam logic [1:0] MODE_REAL = 2'b00;
   localparam logic [1:0] MODE_PROT = 2'b01;
   localparam logic [1:0] MODE_V86  = 2'b10;

   localparam int DESC_W = 32;

endpackage

// File: rtl/sar_sel_decode.sv
module sar_sel_decode
   import sar_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LIM_W  = 16
) (
   input  sar_sel_t            sel,
   input  logic [ADDR_W-1:0]   gdt_base,
   input  logic [LIM_W-1:0]    gdt_limit,
   input  logic [ADDR_W-1:0]   ldt_base,
   input  logic [LIM_W-1:0]    ldt_limit,
   output logic                is_null,
   output logic                in_limit,
   output logic [ADDR_W-1:0]   hi_addr
);
   localparam int OFF_W = 16;
   localparam int CMP_W = (LIM_W > OFF_W) ? LIM_W : OFF_W;

   logic [OFF_W-1:0]  last_byte;
   logic [OFF_W-1:0]  hi_off;
   logic [CMP_W-1:0]  last_ext;
   logic [CMP_W-1:0]  lim_ext;
   logic [LIM_W-1:0]  lim_sel;
   logic [ADDR_W-1:0] base_sel;

   assign is_null   = (sel.index == '0) && !sel.local_tbl;
   assign last_byte = {sel.index, 3'b111};
   assign hi_off    = {sel.index, 3'b100};
   assign lim_sel   = sel.local_tbl ? ldt_limit : gdt_limit;
   assign base_sel  = sel.local_tbl ? ldt_base  : gdt_base;
   assign last_ext  = CMP_W'(last_byte);
   assign lim_ext   = CMP_W'(lim_sel);
   assign in_limit  = (last_ext <= lim_ext);
   assign hi_addr   = base_sel + ADDR_W'(hi_off);

endmodule

// File: rtl/sar_desc_check.sv
module sar_desc_check #(
   parameter logic [15:0] SYS_TYPE_OK = 16'h1A3E
) (
   input  logic [6:0] attr,
   input  logic [1:0] cpl,
   input  logic [1:0] rpl,
   output logic       type_ok,
   output logic       priv_ok,
   output logic       pass
);
   logic [3:0]  typ;
   logic        code_data;
   logic [1:0]  dpl;
   logic        conforming;
   logic [15:0] sys_ok_vec;

   assign typ       = attr[3:0];
   assign code_data = attr[4];
   assign dpl       = attr[6:5];

   genvar g;
   generate
      for (g = 0; g < 16; g++) begin : g_sys_ok
         assign sys_ok_vec[g] = SYS_TYPE_OK[g];
      end
   endgenerate

   assign conforming = code_data && typ[3] && typ[2];
   assign type_ok    = code_data || sys_ok_vec[typ];
   assign priv_ok    = conforming || ((cpl <= dpl) && (rpl <= dpl));
   assign pass       = type_ok && priv_ok;

endmodule

// File: rtl/sar_rights_mask.sv
module sar_rights_mask #(
   parameter bit UNDEF_NIB_PASS = 1'b1
) (
   input  logic [31:0] desc_hi,
   input  logic        op32,
   output logic [31:0] rights
);
   logic [31:0] wide;
   logic [31:0] narrow;

   generate
      if (UNDEF_NIB_PASS) begin : g_nib_pass
         assign wide = desc_hi & 32'h00FF_FF00;
      end else begin : g_nib_zero
         assign wide = desc_hi & 32'h00F0_FF00;
      end
   endgenerate

   assign narrow = {16'h0000, desc_hi[15:8], 8'h00};
   assign rights = op32 ? wide : narrow;

endmodule

// File: rtl/sar_check_unit.sv
module sar_check_unit
   import sar_pkg::*;
#(
   parameter int          ADDR_W         = 32,
   parameter int          LIM_W          = 16,
   parameter logic [15:0] SYS_TYPE_OK    = 16'h1A3E,
   parameter bit          UNDEF_NIB_PASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [15:0]       sel_i,
   input  logic [1:0]        cpl_i,
   input  logic              op32_i,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] gdt_base_i,
   input  logic [LIM_W-1:0]  gdt_limit_i,
   input  logic [ADDR_W-1:0] ldt_base_i,
   input  logic [LIM_W-1:0]  ldt_limit_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [31:0]       rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              zf_o,
   output logic              we_o,
   output logic              ud_fault_o,
   output logic [31:0]       result_o
);
   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ADDR_W must be at least 16");
      end
      if (LIM_W < 3) begin : g_bad_lim
         $error("LIM_W must be at least 3");
      end
   endgenerate

   sar_state_e        st_q, st_d;
   sar_sel_t          sel_q;
   logic [1:0]        cpl_q;
   logic              op32_q;
   logic [ADDR_W-1:0] gbase_q, lbase_q, addr_q;
   logic [LIM_W-1:0]  glim_q, llim_q;
   logic              issued_q;
   logic [DESC_W-1:0] desc_q;
   logic              zf_q, we_q, ud_q;
   logic [31:0]       result_q;

   logic              sel_null, sel_inlim;
   logic [ADDR_W-1:0] dec_addr;
   logic              d_type_ok, d_priv_ok, d_pass;
   logic [31:0]       masked;

   sar_sel_decode #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) i_sel_decode (
      .sel       (sel_q),
      .gdt_base  (gbase_q),
      .gdt_limit (glim_q),
      .ldt_base  (lbase_q),
      .ldt_limit (llim_q),
      .is_null   (sel_null),
      .in_limit  (sel_inlim),
      .hi_addr   (dec_addr)
   );

   sar_desc_check #(.SYS_TYPE_OK(SYS_TYPE_OK)) i_desc_check (
      .attr    (desc_q[14:8]),
      .cpl     (cpl_q),
      .rpl     (sel_q.rpl),
      .type_ok (d_type_ok),
      .priv_ok (d_priv_ok),
      .pass    (d_pass)
   );

   sar_rights_mask #(.UNDEF_NIB_PASS(UNDEF_NIB_PASS)) i_rights_mask (
      .desc_hi (desc_q),
      .op32    (op32_q),
      .rights  (masked)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:       if (start_i) st_d = (mode_i == MODE_PROT) ? ST_CHECK_SEL : ST_DONE;
         ST_CHECK_SEL:  st_d = (sel_null || !sel_inlim) ? ST_DONE : ST_READ;
         ST_READ:       if (rd_valid_i) st_d = ST_CHECK_DESC;
         ST_CHECK_DESC: st_d = ST_DONE;
         ST_DONE:       st_d = ST_IDLE;
         default:       st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         sel_q    <= '0;
         cpl_q    <= '0;
         op32_q   <= 1'b0;
         gbase_q  <= '0;
         lbase_q  <= '0;
         glim_q   <= '0;
         llim_q   <= '0;
         addr_q   <= '0;
         issued_q <= 1'b0;
         desc_q   <= '0;
         zf_q     <= 1'b0;
         we_q     <= 1'b0;
         ud_q     <= 1'b0;
         result_q <= '0;
      end else begin
         st_q <= st_d;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  sel_q   <= sar_sel_t'(sel_i);
                  cpl_q   <= cpl_i;
                  op32_q  <= op32_i;
                  gbase_q <= gdt_base_i;
                  lbase_q <= ldt_base_i;
                  glim_q  <= gdt_limit_i;
                  llim_q  <= ldt_limit_i;
                  zf_q    <= 1'b0;
                  we_q    <= 1'b0;
                  ud_q    <= (mode_i != MODE_PROT);
               end
            end
            ST_CHECK_SEL: begin
               addr_q   <= dec_addr;
               issued_q <= 1'b0;
            end
            ST_READ: begin
               issued_q <= 1'b1;
               if (rd_valid_i) begin
                  desc_q   <= rd_data_i;
                  issued_q <= 1'b0;
               end
            end
            ST_CHECK_DESC: begin
               if (d_pass) begin
                  zf_q     <= 1'b1;
                  we_q     <= 1'b1;
                  result_q <= masked;
               end
            end
            default: ;
         endcase
      end
   end

   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = (st_q == ST_DONE);
   assign zf_o       = done_o && zf_q;
   assign we_o       = done_o && we_q;
   assign ud_fault_o = done_o && ud_q;
   assign rd_req_o   = (st_q == ST_READ) && !issued_q;
   assign rd_addr_o  = addr_q;
   assign result_o   = result_q;

endmodule

// File: rtl/sar_check_unit_chk.sv
module sar_check_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        busy_o,
   input logic        done_o,
   input logic        zf_o,
   input logic        we_o,
   input logic        ud_fault_o,
   input logic        rd_req_o,
   input logic [31:0] result_o
);
   // R12: completion lasts one cycle
   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R12: write-enable only with a set flag at completion
   p_we_with_zf_r12: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> (zf_o && done_o));

   // R12: destination changes only on a write
   p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> we_o);

   // R2: a mode fault never reports success
   p_ud_no_zf_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ud_fault_o |-> (done_o && !zf_o && !we_o));

   // R5: read request is a single-cycle pulse
   p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);

   // R5: requests only during an operation
   p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> busy_o);

   // R10: the masked result never carries bits outside 23:8
   p_mask_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> (result_o[7:0] == 8'h00 && result_o[31:24] == 8'h00));

   // R14: an accepted start makes the unit busy
   p_start_busy_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);
endmodule

bind sar_check_unit sar_check_unit_chk i_sar_check_unit_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .zf_o       (zf_o),
   .we_o       (we_o),
   .ud_fault_o (ud_fault_o),
   .rd_req_o   (rd_req_o),
   .result_o   (result_o)
);

// File: tb/test_sar_check_unit.sv
`timescale 1ns/1ps
module test_sar_check_unit;
   localparam int ADDR_W = 32;
   localparam int LIM_W  = 16;
   localparam logic [31:0] GBASE = 32'h0000_1000;
   localparam logic [15:0] GLIM  = 16'h00FF;
   localparam logic [31:0] LBASE = 32'h0000_8000;
   localparam logic [15:0] LLIM  = 16'h003F;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [15:0]       sel_i = '0;
   logic [1:0]        cpl_i = '0;
   logic              op32_i = 1'b1;
   logic [1:0]        mode_i = 2'b01;
   logic [ADDR_W-1:0] gdt_base_i = GBASE;
   logic [LIM_W-1:0]  gdt_limit_i = GLIM;
   logic [ADDR_W-1:0] ldt_base_i = LBASE;
   logic [LIM_W-1:0]  ldt_limit_i = LLIM;
   logic              rd_req_o;
   logic [ADDR_W-1:0] rd_addr_o;
   logic              rd_valid_i = 1'b0;
   logic [31:0]       rd_data_i = '0;
   logic              busy_o, done_o, zf_o, we_o, ud_fault_o;
   logic [31:0]       result_o;

   int          vectors = 0;
   int          miscompares = 0;
   logic [31:0] mem_word = '0;
   int          mem_wait = 0;
   int          req_cnt = 0;
   logic [31:0] last_addr = '0;
   bit          pend = 0;
   int          wcnt = 0;

   int          got_lat;
   logic        got_zf, got_we, got_ud, got_done_after;
   logic [31:0] got_res;

   always #2 clk = ~clk;

   sar_check_unit #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) i_sar_check_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i), .cpl_i(cpl_i),
      .op32_i(op32_i), .mode_i(mode_i), .gdt_base_i(gdt_base_i), .gdt_limit_i(gdt_limit_i),
      .ldt_base_i(ldt_base_i), .ldt_limit_i(ldt_limit_i), .rd_req_o(rd_req_o),
      .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
      .busy_o(busy_o), .done_o(done_o), .zf_o(zf_o), .we_o(we_o),
      .ud_fault_o(ud_fault_o), .result_o(result_o)
   );

   // memory model: answers mem_wait cycles after the request is seen
   always @(negedge clk) begin
      rd_valid_i <= 1'b0;
      if (rd_req_o) begin
         pend = 1;
         wcnt = mem_wait;
         req_cnt++;
         last_addr = rd_addr_o;
      end
      if (pend) begin
         if (wcnt == 0) begin
            rd_valid_i <= 1'b1;
            rd_data_i  <= mem_word;
            pend = 0;
         end else begin
            wcnt--;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rights(input logic [31:0] d, input logic op32);
      return op32 ? (d & 32'h00FF_FF00) : {16'h0000, d[15:8], 8'h00};
   endfunction

   function automatic bit exp_pass(input logic [31:0] d, input logic [1:0] cpl, input logic [1:0] rpl);
      logic [15:0] ok_sys;
      bit t_ok, conf, p_ok;
      ok_sys = '0;
      ok_sys[1] = 1; ok_sys[2] = 1; ok_sys[3] = 1; ok_sys[4] = 1;
      ok_sys[5] = 1; ok_sys[9] = 1; ok_sys[11] = 1; ok_sys[12] = 1;
      t_ok = d[12] ? 1'b1 : ok_sys[d[11:8]];
      conf = d[12] && d[11] && d[10];
      p_ok = conf || (cpl <= d[14:13] && sel_rpl_le(rpl, d[14:13]));
      return t_ok && p_ok;
   endfunction

   function automatic bit sel_rpl_le(input logic [1:0] a, input logic [1:0] b);
      return a <= b;
   endfunction

   task automatic run_op(input logic [15:0] sel, input logic [1:0] cpl, input logic op32,
                         input logic [1:0] mode, input logic [31:0] desc, input int wait_c);
      mem_word = desc;
      mem_wait = wait_c;
      req_cnt  = 0;
      @(negedge clk);
      sel_i = sel; cpl_i = cpl; op32_i = op32; mode_i = mode; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      got_lat = 1;
      while (!done_o && got_lat < 20) begin
         @(negedge clk);
         got_lat++;
      end
      got_zf = zf_o; got_we = we_o; got_ud = ud_fault_o; got_res = result_o;
      @(negedge clk);
      got_done_after = done_o;
   endtask

   // full check of one protected-mode operation
   task automatic do_prot(input string tag, input logic [15:0] sel, input logic [1:0] cpl,
                          input logic op32, input logic [31:0] desc, input bit sel_ok,
                          input logic [31:0] exp_addr);
      logic [31:0] prev;
      bit pass;
      prev = result_o;
      run_op(sel, cpl, op32, 2'b01, desc, 0);
      pass = sel_ok && exp_pass(desc, cpl, sel[1:0]);
      chk(got_lat == (sel_ok ? 4 : 2), {tag, " R13 latency"}, got_lat, sel_ok ? 4 : 2);
      chk(got_zf == pass, {tag, " R12 zf"}, got_zf, pass);
      chk(got_we == pass, {tag, " R12 we"}, got_we, pass);
      chk(got_res == (pass ? exp_rights(desc, op32) : prev), {tag, " R12 result"},
          got_res, pass ? exp_rights(desc, op32) : prev);
      chk(req_cnt == (sel_ok ? 1 : 0), {tag, " R5 read count"}, req_cnt, sel_ok ? 1 : 0);
      if (sel_ok) chk(last_addr == exp_addr, {tag, " R5 address"}, last_addr, exp_addr);
      chk(got_done_after == 1'b0, {tag, " R12 done one cycle"}, got_done_after, 0);
   endtask

   task automatic t_reset;
      chk(!done_o && !busy_o && !rd_req_o, "R1 control idle", {done_o, busy_o, rd_req_o}, 0);
      chk(!zf_o && !we_o && !ud_fault_o, "R1 flags clear", {zf_o, we_o, ud_fault_o}, 0);
      chk(result_o == 0, "R1 result zero", result_o, 0);
   endtask

   task automatic t_modes;
      logic [1:0] m [3];
      m[0] = 2'b00; m[1] = 2'b10; m[2] = 2'b11;
      foreach (m[i]) begin
         run_op(16'h0010, 2'd0, 1'b1, m[i], 32'h00CF_9200, 0);
         chk(got_ud == 1'b1, "R2 fault raised", got_ud, 1);
         chk(!got_zf && !got_we, "R2 no success", {got_zf, got_we}, 0);
         chk(req_cnt == 0, "R2 no read", req_cnt, 0);
         chk(got_lat == 1, "R13 fault latency", got_lat, 1);
      end
   endtask

   task automatic t_null;
      do_prot("R3 null 0000", 16'h0000, 2'd0, 1'b1, 32'h0000_9200, 0, 0);
      do_prot("R3 null 0003", 16'h0003, 2'd0, 1'b1, 32'h0000_F200, 0, 0);
      do_prot("R3 local idx0", 16'h0004, 2'd0, 1'b1, 32'h0012_9300, 1, LBASE + 32'h4);
   endtask

   task automatic t_limits;
      do_prot("R4 gdt last", 16'h00F8, 2'd0, 1'b1, 32'h0040_9A00, 1, GBASE + 32'hFC);
      do_prot("R4 gdt over", 16'h0100, 2'd0, 1'b1, 32'h0040_9A00, 0, 0);
      do_prot("R4 ldt last", 16'h003C, 2'd0, 1'b1, 32'h0080_9200, 1, LBASE + 32'h3C);
      do_prot("R4 ldt over", 16'h0044, 2'd0, 1'b1, 32'h0080_9200, 0, 0);
   endtask

   task automatic t_sys_types;
      for (int t = 0; t < 16; t++) begin
         do_prot("R7 system type", 16'h0018, 2'd0, 1'b1, 32'h0000_E000 | (t << 8), 1, GBASE + 32'h1C);
      end
   endtask

   task automatic t_code_data;
      for (int t = 0; t < 16; t++) begin
         do_prot("R6 code/data type", 16'h0021, 2'd3, 1'b1, 32'h00F0_F000 | (t << 8), 1, GBASE + 32'h24);
      end
   endtask

   task automatic t_priv;
      do_prot("R8 cpl0 rpl0", 16'h0028, 2'd0, 1'b1, 32'h0000_B200, 1, GBASE + 32'h2C);
      do_prot("R8 cpl2 fail", 16'h0028, 2'd2, 1'b1, 32'h0000_B200, 1, GBASE + 32'h2C);
      do_prot("R8 rpl2 fail", 16'h002A, 2'd0, 1'b1, 32'h0000_B200, 1, GBASE + 32'h2C);
      do_prot("R8 cpl1 rpl1", 16'h0029, 2'd1, 1'b1, 32'h0000_B200, 1, GBASE + 32'h2C);
      do_prot("R8 nonconf code", 16'h002B, 2'd3, 1'b1, 32'h0000_9A00, 1, GBASE + 32'h2C);
      do_prot("R9 conforming", 16'h002B, 2'd3, 1'b1, 32'h0000_9E00, 1, GBASE + 32'h2C);
   endtask

   task automatic t_masks;
      do_prot("R10 wide mask", 16'h0030, 2'd0, 1'b1, 32'hABCD_F2FF, 1, GBASE + 32'h34);
      chk(got_res == 32'h00CD_F200, "R10 literal", got_res, 32'h00CD_F200);
      do_prot("R11 narrow mask", 16'h0030, 2'd0, 1'b0, 32'hABCD_F2FF, 1, GBASE + 32'h34);
      chk(got_res == 32'h0000_F200, "R11 literal", got_res, 32'h0000_F200);
      do_prot("R12 fail keeps", 16'h0030, 2'd3, 1'b1, 32'h1234_9200, 1, GBASE + 32'h34);
      chk(got_res == 32'h0000_F200, "R12 unchanged", got_res, 32'h0000_F200);
   endtask

   task automatic t_wait;
      run_op(16'h0038, 2'd0, 1'b1, 2'b01, 32'h0055_9300, 2);
      chk(got_lat == 6, "R13 waited latency", got_lat, 6);
      chk(req_cnt == 1, "R5 one request while waiting", req_cnt, 1);
      chk(got_zf && got_res == 32'h0055_9300, "R12 waited result", got_res, 32'h0055_9300);
   endtask

   task automatic t_busy_start;
      int lat;
      mem_word = 32'h0011_9200; mem_wait = 1; req_cnt = 0;
      @(negedge clk);
      sel_i = 16'h0040; cpl_i = 0; op32_i = 1; mode_i = 2'b01; start_i = 1'b1;
      @(negedge clk);
      sel_i = 16'h0048; mode_i = 2'b00;
      lat = 1;
      @(negedge clk);
      lat++;
      start_i = 1'b0;
      while (!done_o && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == 5, "R14 latency unaffected", lat, 5);
      chk(zf_o && !ud_fault_o, "R14 first op completes", {zf_o, ud_fault_o}, 2'b10);
      chk(req_cnt == 1 && last_addr == GBASE + 32'h44, "R14 first address", last_addr, GBASE + 32'h44);
      @(negedge clk);
      @(negedge clk);
      chk(!busy_o, "R14 no second op", busy_o, 0);
   endtask

   initial begin
      #400000;
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_modes();
      t_null();
      t_limits();
      t_sys_types();
      t_code_data();
      t_priv();
      t_masks();
      t_wait();
      t_busy_start();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule